// File: doc/BRIEF.md
# Wishbone to Byte-Wide SRAM Bridge

This block links a 32-bit Wishbone-style processor bus to an external asynchronous static RAM that has an 8-bit data port. It takes one bus request at a time and turns it into a series of byte accesses, one for each lane of the 32-bit word. It builds up the read word from those bytes and gives one acknowledge pulse when the last lane is finished.

Writes respect the byte selects, so 8-bit and 16-bit stores change only the bytes they name. Reads always fetch all four bytes of the addressed word. The SRAM port uses a 19-bit byte address (512 KiB). The 8-bit data path is split into an output, an input and an output enable, so a pad or a model outside the block can resolve the bidirectional pin.

Top module: `wb_sram_bridge`

## Requirements
- R1: A request is accepted only in a cycle where wbCyc and wbStb are both high. With wbStb high and wbCyc low, the SRAM controls stay inactive and no acknowledge appears.
- R2: After reset and while idle, sramCeN, sramOeN and sramWeN are high, and sramDOe and wbAck are low.
- R3: Bus lane k (bits 8k+7..8k) maps to SRAM byte address {wbAdr[18:2], k[1:0]}. Lanes are processed in ascending order 0, 1, 2, 3.
- R4: On a write, each lane whose wbSel bit is 1 gets exactly one low pulse on sramWeN. A lane whose wbSel bit is 0 gets no pulse, and its SRAM byte is left unchanged.
- R5: A selected write lane takes four clocks: lane decision, setup, write-enable low for one clock, and hold with the enable high again. The address and data stay steady from setup to the end of hold. An unselected write lane takes one clock.
- R6: A read takes three clocks per lane (decision, address with sramOeN low, capture). It fetches all four lanes, and wbDatR holds the little-endian word when wbAck is high.
- R7: wbAck is high for exactly one clock. It is high in the Nth cycle after the accepting edge, where N is 4 + 3*(number of set wbSel bits) for a write and 12 for a read.
- R8: After an acknowledge, the block starts no new access until wbCyc and wbStb have not been high together for at least one clock.
- R9: sramDOe is high only during write lane phases, and never while sramOeN is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbCyc | input | 1 | Bus cycle valid |
| wbStb | input | 1 | Bus strobe |
| wbWe | input | 1 | 1 = write, 0 = read |
| wbAdr | input | 32 | Byte address (bits 18..2 used) |
| wbDatW | input | 32 | Write data |
| wbSel | input | 4 | Byte selects, bit k for lane k |
| wbDatR | output | 32 | Read data |
| wbAck | output | 1 | One-clock acknowledge |
| sramAddr | output | 19 | SRAM byte address |
| sramDOut | output | 8 | Data driven to the SRAM |
| sramDIn | input | 8 | Data returned by the SRAM |
| sramDOe | output | 1 | Enable for the data pin driver |
| sramCeN | output | 1 | Chip enable, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |

## Verification
The acknowledge is due a fixed number of cycles after the accepting edge: 12 for a read, and 4 plus 3 per selected lane for a write. For every transfer the bench counts falling clock edges from the accepting edge and compares the count with that formula, which it computes from the select mask. Read data, the count of write pulses and the lane addresses seen at each pulse are sampled at the acknowledge cycle or at the pulse itself. These values are compared with a byte-level reference memory that the bench maintains. Pin checks for the idle state and for ignored strobes are taken at falling edges, between rising edges, so every register involved has already settled.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EVAL,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RADDR,
    ST_RCAP,
    ST_ACK,
    ST_REARM
  } bridgeState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch request, clear lane index
    logic laneStep;   // move to next lane
    logic capture;    // store SRAM byte into current lane
    logic driveData;  // enable data pin driver
    logic chipSel;    // chip enable active
    logic readEn;     // output enable active
    logic writeEn;    // write enable active
    logic ack;        // bus acknowledge
  } bridgeStrobes_t;

endpackage

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sram_bridge_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic           reqWrite,
  input  logic           laneSel,
  input  logic           laneLast,
  output bridgeStrobes_t strb
);

  bridgeState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          stateD    = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (!reqWrite) begin
          stateD = ST_RADDR;
        end else if (laneSel) begin
          stateD = ST_WSETUP;
        end else if (laneLast) begin
          stateD = ST_ACK;
        end else begin
          strb.laneStep = 1'b1;
          stateD        = ST_EVAL;
        end
      end
      ST_WSETUP: begin
        strb.chipSel   = 1'b1;
        strb.driveData = 1'b1;
        stateD         = ST_WPULSE;
      end
      ST_WPULSE: begin
        strb.chipSel   = 1'b1;
        strb.driveData = 1'b1;
        strb.writeEn   = 1'b1;
        stateD         = ST_WHOLD;
      end
      ST_WHOLD: begin
        strb.chipSel   = 1'b1;
        strb.driveData = 1'b1;
        if (laneLast) begin
          stateD = ST_ACK;
        end else begin
          strb.laneStep = 1'b1;
          stateD        = ST_EVAL;
        end
      end
      ST_RADDR: begin
        strb.chipSel = 1'b1;
        strb.readEn  = 1'b1;
        stateD       = ST_RCAP;
      end
      ST_RCAP: begin
        strb.chipSel = 1'b1;
        strb.readEn  = 1'b1;
        strb.capture = 1'b1;
        if (laneLast) begin
          stateD = ST_ACK;
        end else begin
          strb.laneStep = 1'b1;
          stateD        = ST_EVAL;
        end
      end
      ST_ACK: begin
        strb.ack = 1'b1;
        stateD   = ST_REARM;
      end
      ST_REARM: begin
        if (!reqValid) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sbr_datapath.sv
module sbr_datapath
  import sram_bridge_pkg::*;
#(
  parameter int BUS_ADDR_W = 32,
  parameter int ADDR_W     = 19,
  parameter int BYTE_W     = 8,
  parameter int LANES      = 4,
  localparam int DATA_W    = BYTE_W * LANES,
  localparam int LANE_W    = $clog2(LANES),
  localparam int WORD_W    = ADDR_W - LANE_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bridgeStrobes_t        strb,
  input  logic [BUS_ADDR_W-1:0] wbAdr,
  input  logic [DATA_W-1:0]     wbDatW,
  input  logic [LANES-1:0]      wbSel,
  input  logic                  wbWe,
  input  logic [BYTE_W-1:0]     sramDIn,
  output logic [DATA_W-1:0]     wbDatR,
  output logic [ADDR_W-1:0]     sramAddr,
  output logic [BYTE_W-1:0]     sramDOut,
  output logic                  reqWrite,
  output logic                  laneSel,
  output logic                  laneLast
);

  logic [WORD_W-1:0] wordQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [LANES-1:0]  selQ;
  logic [LANE_W-1:0] laneQ;
  logic [BYTE_W-1:0] wrBytes [LANES];
  logic [BYTE_W-1:0] rdBytes [LANES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ    <= '0;
      wrDataQ  <= '0;
      selQ     <= '0;
      reqWrite <= 1'b0;
      laneQ    <= '0;
    end else if (strb.load) begin
      wordQ    <= wbAdr[ADDR_W-1:LANE_W];
      wrDataQ  <= wbDatW;
      selQ     <= wbSel;
      reqWrite <= wbWe;
      laneQ    <= '0;
    end else if (strb.laneStep) begin
      laneQ    <= laneQ + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign wrBytes[g] = wrDataQ[g*BYTE_W +: BYTE_W];

    always_ff @(posedge clk) begin
      if (!rstN)
        rdBytes[g] <= '0;
      else if (strb.capture && laneQ == LANE_W'(g))
        rdBytes[g] <= sramDIn;
    end

    assign wbDatR[g*BYTE_W +: BYTE_W] = rdBytes[g];
  end

  assign sramAddr = {wordQ, laneQ};
  assign sramDOut = wrBytes[laneQ];
  assign laneSel  = selQ[laneQ];
  assign laneLast = (laneQ == LANE_W'(LANES - 1));

endmodule

// File: rtl/wb_sram_bridge.sv
module wb_sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int BUS_ADDR_W = 32,
  parameter int ADDR_W     = 19,
  parameter int BYTE_W     = 8,
  parameter int LANES      = 4,
  localparam int DATA_W    = BYTE_W * LANES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wbCyc,
  input  logic                  wbStb,
  input  logic                  wbWe,
  input  logic [BUS_ADDR_W-1:0] wbAdr,
  input  logic [DATA_W-1:0]     wbDatW,
  input  logic [LANES-1:0]      wbSel,
  output logic [DATA_W-1:0]     wbDatR,
  output logic                  wbAck,
  output logic [ADDR_W-1:0]     sramAddr,
  output logic [BYTE_W-1:0]     sramDOut,
  input  logic [BYTE_W-1:0]     sramDIn,
  output logic                  sramDOe,
  output logic                  sramCeN,
  output logic                  sramOeN,
  output logic                  sramWeN
);

  bridgeStrobes_t strb;
  logic reqWrite, laneSel, laneLast;

  sbr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (wbCyc & wbStb),
    .reqWrite (reqWrite),
    .laneSel  (laneSel),
    .laneLast (laneLast),
    .strb     (strb)
  );

  sbr_datapath #(
    .BUS_ADDR_W (BUS_ADDR_W),
    .ADDR_W     (ADDR_W),
    .BYTE_W     (BYTE_W),
    .LANES      (LANES)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wbAdr    (wbAdr),
    .wbDatW   (wbDatW),
    .wbSel    (wbSel),
    .wbWe     (wbWe),
    .sramDIn  (sramDIn),
    .wbDatR   (wbDatR),
    .sramAddr (sramAddr),
    .sramDOut (sramDOut),
    .reqWrite (reqWrite),
    .laneSel  (laneSel),
    .laneLast (laneLast)
  );

  assign wbAck   = strb.ack;
  assign sramDOe = strb.driveData;
  assign sramCeN = ~strb.chipSel;
  assign sramOeN = ~strb.readEn;
  assign sramWeN = ~strb.writeEn;

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int ADDR_W = 19,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wbAck,
  input logic [ADDR_W-1:0] sramAddr,
  input logic [BYTE_W-1:0] sramDOut,
  input logic              sramDOe,
  input logic              sramCeN,
  input logic              sramOeN,
  input logic              sramWeN
);

  AST_DRIVE_NOT_WHILE_READ: assert property (@(posedge clk) disable iff (!rstN)
    sramDOe |-> sramOeN); // R9

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |=> !wbAck); // R7

  AST_WE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |=> sramWeN); // R5

  AST_WE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (!sramCeN && sramDOe)); // R4

  AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |=> ($stable(sramAddr) && $stable(sramDOut) && !sramCeN)); // R5

  AST_SETUP_BEFORE_WE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sramWeN) |-> ($stable(sramAddr) && $stable(sramDOut))); // R5

  AST_ACK_PINS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |-> (sramCeN && sramOeN && sramWeN && !sramDOe)); // R2

endmodule

bind wb_sram_bridge sbr_checker #(
  .ADDR_W (ADDR_W),
  .BYTE_W (BYTE_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wbAck    (wbAck),
  .sramAddr (sramAddr),
  .sramDOut (sramDOut),
  .sramDOe  (sramDOe),
  .sramCeN  (sramCeN),
  .sramOeN  (sramOeN),
  .sramWeN  (sramWeN)
);

// File: tb/sim_wb_sram_bridge.sv
module sim_wb_sram_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wbCyc = 1'b0, wbStb = 1'b0, wbWe = 1'b0;
  logic [31:0] wbAdr = '0, wbDatW = '0;
  logic [3:0]  wbSel = '0;
  logic [31:0] wbDatR;
  logic        wbAck;
  logic [18:0] sramAddr;
  logic [7:0]  sramDOut, sramDIn;
  logic        sramDOe, sramCeN, sramOeN, sramWeN;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit modelOn = 1'b0;

  logic [7:0]  sMem   [1024];
  logic [7:0]  refMem [1024];
  int          weCount = 0;
  logic [18:0] weLog [8];

  always #5 clk = ~clk;

  wb_sram_bridge u0 (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatW(wbDatW), .wbSel(wbSel), .wbDatR(wbDatR), .wbAck(wbAck),
    .sramAddr(sramAddr), .sramDOut(sramDOut), .sramDIn(sramDIn), .sramDOe(sramDOe),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN)
  );

  // byte-wide asynchronous SRAM model, bench-side only
  assign sramDIn = (!sramCeN && !sramOeN) ? sMem[sramAddr[9:0]] : 8'h00;

  always @(posedge sramWeN)
    if (modelOn && !sramCeN && sramDOe) sMem[sramAddr[9:0]] <= sramDOut;

  always @(negedge sramWeN)
    if (modelOn) begin
      if (weCount < 8) weLog[weCount] = sramAddr;
      weCount++;
    end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int popSel(input logic [3:0] s);
    int n = 0;
    for (int k = 0; k < 4; k++) if (s[k]) n++;
    return n;
  endfunction

  function automatic int expLatency(input bit we, input logic [3:0] s);
    return we ? 4 + 3 * popSel(s) : 12;
  endfunction

  function automatic logic [31:0] refWord(input logic [31:0] adr);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[k*8 +: 8] = refMem[{adr[9:2], 2'(k)}];
    return w;
  endfunction

  // one bus transfer; returns read data, latency and a drive-conflict flag
  task automatic xfer(input bit we, input logic [31:0] adr, input logic [31:0] dat,
                      input logic [3:0] sel, output logic [31:0] rd, output int lat,
                      output bit conflict, input bit holdAfter);
    @(negedge clk);
    weCount = 0;
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = we; wbAdr = adr; wbDatW = dat; wbSel = sel;
    @(posedge clk);
    lat = 0;
    conflict = 1'b0;
    forever begin
      @(negedge clk);
      if (sramDOe && !sramOeN) conflict = 1'b1;
      if (wbAck) break;
      lat++;
      if (lat > 64) break;
    end
    rd = wbDatR;
    if (holdAfter) begin
      // R8: request kept high after ack must not start a new access
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(!wbAck && sramCeN, "R8", "no restart while strobe held", {30'd0, wbAck, sramCeN}, 32'h1);
      end
    end else begin
      @(negedge clk);
      check(!wbAck, "R7", "ack lasts one clock", {31'd0, wbAck}, 32'h0);
    end
    wbCyc = 1'b0; wbStb = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd, adr, dat, expW;
    logic [3:0]  sel;
    int          lat;
    bit          conf, we;
    void'($urandom(32'd20240518));
    for (int i = 0; i < 1024; i++) begin
      sMem[i]   = 8'(i * 37 + 5);
      refMem[i] = 8'(i * 37 + 5);
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    modelOn = 1'b1;
    @(negedge clk);
    check(sramCeN && sramOeN && sramWeN && !sramDOe && !wbAck, "R2", "idle pins after reset",
          {27'd0, sramCeN, sramOeN, sramWeN, sramDOe, wbAck}, 32'h1C);

    // R1: strobe without cycle is ignored
    wbStb = 1'b1; wbCyc = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(sramCeN && !wbAck, "R1", "strobe alone ignored", {30'd0, sramCeN, wbAck}, 32'h2);
    end
    wbStb = 1'b0;
    @(negedge clk);

    // R3: full word write, lane address order
    adr = 32'hFF04_1A30;
    xfer(1'b1, adr, 32'hA1B2C3D4, 4'hF, rd, lat, conf, 1'b0);
    for (int k = 0; k < 4; k++) refMem[{adr[9:2], 2'(k)}] = 8'(32'hA1B2C3D4 >> (8 * k));
    check(weCount == 4, "R4", "pulses for full write", weCount, 4);
    for (int k = 0; k < 4; k++)
      check(weLog[k] == {adr[18:2], 2'(k)}, "R3", "lane address", {13'd0, weLog[k]}, {13'd0, adr[18:2], 2'(k)});
    check(lat == 16, "R7", "full write latency", lat, 16);
    for (int k = 0; k < 4; k++)
      check(sMem[{adr[9:2], 2'(k)}] == refMem[{adr[9:2], 2'(k)}], "R3", "little-endian byte placed",
            {24'd0, sMem[{adr[9:2], 2'(k)}]}, {24'd0, refMem[{adr[9:2], 2'(k)}]});

    // R4: sparse select, skipped lanes untouched
    xfer(1'b1, adr, 32'h11223344, 4'b1010, rd, lat, conf, 1'b0);
    refMem[{adr[9:2], 2'd1}] = 8'h33;
    refMem[{adr[9:2], 2'd3}] = 8'h11;
    check(weCount == 2, "R4", "pulses for sel 1010", weCount, 2);
    check(weLog[0] == {adr[18:2], 2'd1} && weLog[1] == {adr[18:2], 2'd3}, "R3", "skipped lanes order",
          {13'd0, weLog[0]}, {13'd0, adr[18:2], 2'd1});
    check(lat == 10, "R5", "sparse write latency", lat, 10);

    // R5: empty select writes nothing
    xfer(1'b1, adr, 32'hDEADBEEF, 4'b0000, rd, lat, conf, 1'b0);
    check(weCount == 0, "R4", "no pulses for empty select", weCount, 0);
    check(lat == 4, "R5", "empty write latency", lat, 4);

    // R6: read back merged word, hold strobe afterwards (R8)
    xfer(1'b0, adr, 32'h0, 4'h0, rd, lat, conf, 1'b1);
    expW = refWord(adr);
    check(rd == expW, "R6", "read after byte writes", rd, expW);
    check(lat == 12, "R7", "read latency", lat, 12);
    check(!conf, "R9", "no drive during read", {31'd0, conf}, 32'h0);

    // random mix
    for (int t = 0; t < 60; t++) begin
      we  = 1'($urandom);
      adr = $urandom;
      dat = $urandom;
      sel = 4'($urandom);
      xfer(we, adr, dat, sel, rd, lat, conf, 1'b0);
      check(lat == expLatency(we, sel), we ? "R5" : "R6", "latency", lat, expLatency(we, sel));
      check(!conf, "R9", "no drive conflict", {31'd0, conf}, 32'h0);
      if (we) begin
        for (int k = 0; k < 4; k++)
          if (sel[k]) refMem[{adr[9:2], 2'(k)}] = dat[k*8 +: 8];
        check(weCount == popSel(sel), "R4", "pulse count", weCount, popSel(sel));
      end else begin
        expW = refWord(adr);
        check(rd == expW, "R6", "random read data", rd, expW);
      end
    end

    @(negedge clk);
    check(sramCeN && sramOeN && sramWeN && !sramDOe, "R2", "idle pins at end",
          {28'd0, sramCeN, sramOeN, sramWeN, sramDOe}, 32'hE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule